// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit single-precision floating-point operands and returns a correctly rounded single-precision product. A one-cycle `start` pulse captures both operands and a two-bit rounding-mode code. The 24-bit significands, each including the implicit leading one, are multiplied by an iterative shift-add engine. The engine looks at one multiplier bit per cycle and adds the multiplicand only when that bit is set. After 24 steps the 48-bit product is complete. A final cycle normalizes it, rounds it and packs it into `prod`, with a one-cycle `done` pulse.

The result sign is the exclusive OR of the operand signs. The biased result exponent is the sum of the operand exponents, less the bias of 127. The product of two significands lies in [1,4), so normalization needs at most one right shift with an exponent increment. Rounding may carry out of the fraction, and this triggers a second increment. Infinities, NaNs and zeros are decoded before the arithmetic result is used. Results too large for the format become infinity and raise `ovf`. Results below the normal range are flushed to a signed zero and raise `unf`. The block neither produces denormal results nor traps.

Top module: `fp_mul_sp`

## Requirements
- R1: The sign bit (bit 31) of every result other than the quiet NaN equals the XOR of the two operand sign bits.
- R2: For normal operands with an in-range result, the exponent field (bits 30:23) equals EA + EB - 127, plus any normalization and rounding increments. The fraction (bits 22:0) holds the rounded fraction of the product.
- R3: When the significand product is at least 2, it is shifted right by one bit and the exponent is incremented. For example, 1.5 x 1.5 gives 0x40100000.
- R4: `rmode` selects the rounding. 2'b00 rounds to nearest with ties to even. 2'b01 rounds toward zero. 2'b10 rounds toward +infinity. 2'b11 rounds toward -infinity. The round bit is the first product bit below the 23 kept fraction bits. The sticky bit is the OR of all the bits below it.
- R5: If rounding carries out of the fraction, the fraction becomes zero and the exponent is incremented once more. For example, 0x3F800001 x 0x3FFFFFFE gives 0x40000000 under mode 2'b00.
- R6: A final biased exponent of 255 or more gives a signed infinity (exponent field 0xFF, fraction 0) and sets `ovf` for that result.
- R7: A biased exponent below 1, computed before rounding, gives a signed zero and sets `unf`. An operand whose exponent field is 0 is treated as a zero.
- R8: A NaN operand gives 0x7FC00000 with both flags clear. So does zero times infinity, in either order.
- R9: Infinity times a nonzero value gives a signed infinity. Zero times a finite value gives a signed zero. Both flags are clear in these cases.
- R10: A `start` pulse is accepted when the unit is idle. `done` is high for exactly one cycle, on the 25th rising edge after the accepting edge. `prod`, `ovf` and `unf` keep their values until the next `done`.
- R11: A `start` pulse that arrives while an operation is in progress has no effect. That operation completes with its own operands, and no extra `done` pulse appears.
- R12: After reset, `prod`, `done`, `ovf` and `unf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opa | input | 32 | First operand, single precision |
| opb | input | 32 | Second operand, single precision |
| rmode | input | 2 | Rounding mode code (see R4) |
| prod | output | 32 | Rounded product |
| done | output | 1 | One-cycle pulse marking a new result |
| ovf | output | 1 | Result overflowed to infinity |
| unf | output | 1 | Result flushed to zero |

## Verification
The bench targets the rounding corners: a round bit with no sticky, where a design that ignores the even rule leaves an odd fraction, and a fraction of all ones that rounds up, where a missing renormalization wraps the fraction to zero without raising the exponent. It feeds 0 x infinity in both orders and NaN operands, which a design without a special-case decode would turn into an ordinary finite or infinite number. It pushes the exponent sum past both ends of the range, where a design that forgets to remove the bias, or removes it twice, returns nonsense instead of infinity or zero with the matching flag. It also fires `start` in the middle of an operation, where a design without the busy guard would corrupt the product or emit a second `done`.

// File: rtl/fp_mul_sp.sv
module fp_mul_sp #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [EW+FW:0]      opa,
  input  logic [EW+FW:0]      opb,
  input  logic [1:0]          rmode,
  output logic [EW+FW:0]      prod,
  output logic                done,
  output logic                ovf,
  output logic                unf
);
  localparam int W    = EW + FW + 1;
  localparam int SW   = FW + 1;
  localparam int PW   = 2 * SW;
  localparam int CW   = $clog2(SW + 1);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic [W-1:0]  a_q, b_q;
  logic [1:0]    rm_q;
  logic          busy, fin;
  logic [CW-1:0] cnt;
  logic [PW-1:0] acc;

  wire [SW-1:0] mcand = {1'b1, a_q[FW-1:0]};
  wire [SW:0]   psum  = {1'b0, acc[PW-1:SW]} + (acc[0] ? {1'b0, mcand} : {(SW+1){1'b0}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; rm_q <= '0;
      busy <= 1'b0; fin <= 1'b0; cnt <= '0; acc <= '0;
    end else if (start && !busy && !fin) begin
      a_q  <= opa;
      b_q  <= opb;
      rm_q <= rmode;
      busy <= 1'b1;
      cnt  <= '0;
      acc  <= {{SW{1'b0}}, 1'b1, opb[FW-1:0]};
    end else if (busy) begin
      acc <= {psum, acc[SW-1:1]};
      cnt <= cnt + 1'b1;
      if (cnt == CW'(SW - 1)) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  wire [EW-1:0] ea = a_q[W-2:FW];
  wire [EW-1:0] eb = b_q[W-2:FW];
  wire za = (ea == '0);
  wire zb = (eb == '0);
  wire ia = (ea == '1) && (a_q[FW-1:0] == '0);
  wire ib = (eb == '1) && (b_q[FW-1:0] == '0);
  wire na = (ea == '1) && (a_q[FW-1:0] != '0);
  wire nb = (eb == '1) && (b_q[FW-1:0] != '0);
  wire sgn = a_q[W-1] ^ b_q[W-1];

  wire          hi   = acc[PW-1];
  wire [FW-1:0] mant = hi ? acc[PW-2 -: FW] : acc[PW-3 -: FW];
  wire          rbit = hi ? acc[SW-1] : acc[SW-2];
  wire          sbit = hi ? |acc[SW-2:0] : |acc[SW-3:0];

  logic inc;
  always_comb begin
    case (rm_q)
      2'b00:   inc = rbit & (sbit | mant[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~sgn & (rbit | sbit);
      default: inc = sgn & (rbit | sbit);
    endcase
  end

  wire [FW:0] rsum = {1'b0, mant} + {{FW{1'b0}}, inc};

  logic signed [EW+1:0] ex, ef;
  assign ex = $signed({2'b00, ea}) + $signed({2'b00, eb}) - $signed((EW+2)'(BIAS))
            + $signed({{(EW+1){1'b0}}, hi});
  assign ef = ex + $signed({{(EW+1){1'b0}}, rsum[FW]});

  logic [W-1:0] res;
  logic         res_o, res_u;
  always_comb begin
    res_o = 1'b0;
    res_u = 1'b0;
    if (na || nb || (ia && zb) || (za && ib))
      res = QNAN;
    else if (ia || ib)
      res = {sgn, {EW{1'b1}}, {FW{1'b0}}};
    else if (za || zb)
      res = {sgn, {(W-1){1'b0}}};
    else if (ex < $signed((EW+2)'(1))) begin
      res   = {sgn, {(W-1){1'b0}}};
      res_u = 1'b1;
    end else if (ef >= $signed((EW+2)'(EMAX))) begin
      res   = {sgn, {EW{1'b1}}, {FW{1'b0}}};
      res_o = 1'b1;
    end else
      res = {sgn, ef[EW-1:0], rsum[FW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0; done <= 1'b0; ovf <= 1'b0; unf <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        prod <= res;
        ovf  <= res_o;
        unf  <= res_u;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(prod) && $stable(ovf) && $stable(unf));
  assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || fin) |=> $stable(a_q) && $stable(b_q) && $stable(rm_q));
  assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prod != QNAN) |-> prod[W-1] == (a_q[W-1] ^ b_q[W-1]));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> prod[W-2:0] == {{EW{1'b1}}, {FW{1'b0}}} && !unf);
  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf) |-> prod[W-2:0] == '0);
  assert_qnan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prod == QNAN) |-> !ovf && !unf);
  assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(SW) && !fin);
endmodule

// File: tb/fp_mul_sp_test.sv
module fp_mul_sp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [1:0]  rmode = '0;
  logic [31:0] prod;
  logic        done, ovf, unf;

  int checks = 0;
  int errors = 0;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  fp_mul_sp uut (.clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
                 .rmode(rmode), .prod(prod), .done(done), .ovf(ovf), .unf(unf));

  function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] m);
    logic s; logic [7:0] ea, eb; logic [22:0] fa, fb;
    logic [47:0] p; logic hi, r, st, up; logic [22:0] mt; logic [23:0] rs;
    int e;
    s = a[31] ^ b[31]; ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
    if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0)) return {2'b00, 32'h7FC00000};
    if ((ea == 8'hFF && eb == 0) || (eb == 8'hFF && ea == 0)) return {2'b00, 32'h7FC00000};
    if (ea == 8'hFF || eb == 8'hFF) return {2'b00, s, 8'hFF, 23'd0};
    if (ea == 0 || eb == 0) return {2'b00, s, 31'd0};
    p  = {24'd0, 1'b1, fa} * {24'd0, 1'b1, fb};
    hi = p[47];
    if (!hi) p = p << 1;
    mt = p[46:24]; r = p[23]; st = |p[22:0];
    e  = int'(ea) + int'(eb) - 127 + (hi ? 1 : 0);
    if (e < 1) return {2'b01, s, 31'd0};
    case (m)
      2'b00: up = r && (st || mt[0]);
      2'b01: up = 1'b0;
      2'b10: up = !s && (r || st);
      default: up = s && (r || st);
    endcase
    rs = {1'b0, mt} + {23'd0, up};
    if (rs[23]) e = e + 1;
    if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
    return {2'b00, s, e[7:0], rs[22:0]};
  endfunction

  task automatic launch(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] m, input string tag);
    exp_q.push_back(ref_mul(a, b, m));
    tag_q.push_back(tag);
    opa = a; opb = b; rmode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (25) @(negedge clk);
  endtask

  task automatic expect_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                           input logic [33:0] want, input string tag);
    logic [33:0] got;
    got = ref_mul(a, b, m);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s bench model: actual %h expected %h", tag, got, want);
    end
    launch(a, b, m, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected done: actual prod %h expected no result", prod);
      end else begin
        logic [33:0] w; string t;
        w = exp_q.pop_front(); t = tag_q.pop_front();
        if ({ovf, unf, prod} !== w) begin
          errors++;
          $display("FAIL %s: actual ovf=%b unf=%b prod=%h expected ovf=%b unf=%b prod=%h",
                   t, ovf, unf, prod, w[33], w[32], w[31:0]);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({done, ovf, unf, prod} !== 35'd0) begin
      errors++;
      $display("FAIL R12 reset: actual %h expected 0", {done, ovf, unf, prod});
    end
    rst_n = 1'b1;
    @(negedge clk);

    expect_op(32'h3F800000, 32'h3F800000, 2'b00, {2'b00, 32'h3F800000}, "R2 1x1");
    expect_op(32'h3FC00000, 32'h3FC00000, 2'b00, {2'b00, 32'h40100000}, "R3 1.5x1.5");
    expect_op(32'hC0000000, 32'h40400000, 2'b00, {2'b00, 32'hC0C00000}, "R1 -2x3");
    expect_op(32'h3F800001, 32'h3F800001, 2'b00, {2'b00, 32'h3F800002}, "R4 nearest RS=01");
    expect_op(32'h3F800001, 32'h3F800001, 2'b01, {2'b00, 32'h3F800002}, "R4 to zero");
    expect_op(32'h3F800001, 32'h3F800001, 2'b10, {2'b00, 32'h3F800003}, "R4 to +inf");
    expect_op(32'hBF800001, 32'h3F800001, 2'b11, {2'b00, 32'hBF800003}, "R4 to -inf neg");
    expect_op(32'hBF800001, 32'h3F800001, 2'b10, {2'b00, 32'hBF800002}, "R4 to +inf neg");
    expect_op(32'h3F800001, 32'h3FC00000, 2'b00, {2'b00, 32'h3FC00002}, "R4 tie odd");
    expect_op(32'h3F800003, 32'h3FC00000, 2'b00, {2'b00, 32'h3FC00004}, "R4 tie even");
    expect_op(32'h3F800003, 32'h3FC00000, 2'b10, {2'b00, 32'h3FC00005}, "R4 tie up");
    expect_op(32'h3F800001, 32'h3FFFFFFE, 2'b00, {2'b00, 32'h40000000}, "R5 carry");
    expect_op(32'h3F800001, 32'h3FFFFFFE, 2'b01, {2'b00, 32'h3FFFFFFF}, "R5 no carry rz");
    expect_op(32'h7F000000, 32'h7F000000, 2'b00, {2'b10, 32'h7F800000}, "R6 overflow");
    expect_op(32'hFF000000, 32'h7F000000, 2'b01, {2'b10, 32'hFF800000}, "R6 neg overflow");
    expect_op(32'h00800000, 32'h00800000, 2'b00, {2'b01, 32'h00000000}, "R7 underflow");
    expect_op(32'h80800000, 32'h00800000, 2'b00, {2'b01, 32'h80000000}, "R7 neg underflow");
    expect_op(32'h00000001, 32'h3F800000, 2'b00, {2'b00, 32'h00000000}, "R7 denorm as zero");
    expect_op(32'h7F800001, 32'h3F800000, 2'b00, {2'b00, 32'h7FC00000}, "R8 nan a");
    expect_op(32'h40000000, 32'hFFC00123, 2'b00, {2'b00, 32'h7FC00000}, "R8 nan b");
    expect_op(32'h00000000, 32'h7F800000, 2'b00, {2'b00, 32'h7FC00000}, "R8 0xinf");
    expect_op(32'hFF800000, 32'h80000000, 2'b00, {2'b00, 32'h7FC00000}, "R8 infx0");
    expect_op(32'h7F800000, 32'hC0000000, 2'b00, {2'b00, 32'hFF800000}, "R9 infx-2");
    expect_op(32'h80000000, 32'h40A00000, 2'b00, {2'b00, 32'h80000000}, "R9 -0x5");

    // R10: latency and single pulse
    exp_q.push_back(ref_mul(32'h40400000, 32'h40400000, 2'b00));
    tag_q.push_back("R10 latency");
    opa = 32'h40400000; opb = 32'h40400000; rmode = 2'b00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (24) @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++; $display("FAIL R10 early done: actual %b expected 0", done);
    end
    @(negedge clk);
    checks++;
    if (done !== 1'b1) begin
      errors++; $display("FAIL R10 done edge: actual %b expected 1", done);
    end
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || prod !== 32'h41100000) begin
      errors++;
      $display("FAIL R10 hold: actual done=%b prod=%h expected 0 41100000", done, prod);
    end

    // R11: start while busy is ignored
    exp_q.push_back(ref_mul(32'h40000000, 32'h40400000, 2'b00));
    tag_q.push_back("R11 busy start");
    opa = 32'h40000000; opb = 32'h40400000; rmode = 2'b00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    opa = 32'h7F800001; opb = 32'h00000000; rmode = 2'b10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (25) @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      a = {rng[31], 8'd100 + {1'b0, rng[27:23] ^ rng[6:2]}, rng[22:0]};
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      b = (i % 8 == 7) ? rng : {rng[31], 8'd110 + {2'b0, rng[28:23]}, rng[22:0]};
      launch(a, b, rng[1:0], "R2 R4 random");
    end

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing results: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule